// File: doc/BRIEF.md
# Hierarchical Status Register Array

This block gathers status for an instrument in the IEEE-488.2 manner. Four groups of single-cycle event pulses are latched into sticky event registers: communication faults, standard events, overload conditions and reference-clock changes. Once a bit in one of these registers is set, it stays set until software reads that register. The read returns the collected bits and clears them in the same step.

Each event register has a companion enable mask that software can read and write. When a bit is set in both a register and its mask, that group's summary flag turns on inside a status byte. The status byte also carries a live idle indication. A second mask, the service-request enable, selects which status-byte bits feed the master summary bit. That bit appears in the status byte and on a dedicated output.

Software reaches all of this through a plain register port: an address, separate read and write strobes, write data, and registered read data.

Top module: `status_summary_tree`

## Requirements
- R1: After reset, every addressable register reads 0x00. The one exception is the standard event register (address 2), which reads 0x80 because its power-on flag (bit 7) is set by reset. The status byte shows 0x00 while the idle input is low.
- R2: An event pulse on a defined bit sets the matching event register bit. The bit stays set over any number of cycles until that register is read.
- R3: A read strobe returns the register content on `reg_rdata` one clock after the strobe edge. A read of an event register (addresses 0, 2, 4, 6) clears it, so an immediate second read returns 0.
- R4: An event that arrives in the same cycle as a read of its register is missing from that read's data and is present for the next read.
- R5: Each enable register reads back the value written to it, masked to its defined bits. The masks are: communication enable (address 1) 0xFF, standard enable (address 3) 0xFF, overload enable (address 5) 0x07, reference-clock enable (address 7) 0x0F, service-request enable (address 9) 0xBF.
- R6: Undefined bits never read 1: overload event bits 7..3 and reference-clock event bits 7..4. Writes to event registers and to the status byte change nothing.
- R7: Each status-byte summary bit is 1 exactly when its group has a bit set in both the event register and the enable register. The positions are: bit 7 communication, bit 5 standard, bit 1 reference clock, bit 0 overload. Bit 4 follows `idle_in`, and bits 3..2 read 0.
- R8: Status-byte bit 6 and `srq` equal the OR of (status byte AND service-request enable) over every bit except bit 6. They are not sticky and drop when the cause goes away.
- R9: Reading the status byte (address 8) returns its current value and clears no event register.
- R10: Reads of unmapped addresses 10 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comm_evt | input | 8 | Communication-fault event pulses |
| std_evt | input | 8 | Standard event pulses |
| ovl_evt | input | 8 | Overload event pulses (bits 2..0 used) |
| ref_evt | input | 8 | Reference-clock event pulses (bits 3..0 used) |
| idle_in | input | 1 | Live idle indication for status-byte bit 4 |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| stat_byte | output | 8 | Current status byte |
| srq | output | 1 | Master summary (service request) |

## Verification
An event pulse or an enable write is captured on one clock edge. The status byte and `srq` are derived from registers without further delay, so the bench drives on the falling edge and samples them on the next falling edge. Read data is registered, so each read is driven on a falling edge and `reg_rdata` is checked on the falling edge after the capturing rising edge. The event register's clear takes effect on that same rising edge, and the follow-up read and the status-byte checks are timed to see it.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int GRP_N   = 4;
  localparam int GRP_COM = 0;
  localparam int GRP_STD = 1;
  localparam int GRP_OVL = 2;
  localparam int GRP_REF = 3;
  localparam int ADDR_SB  = 8;
  localparam int ADDR_SRE = 9;
  localparam int SB_MSS_BIT  = 6;
  localparam int SB_IDLE_BIT = 4;
  localparam logic [7:0] SRE_MASK = 8'hBF;

  function automatic logic [7:0] grp_mask(input int g);
    case (g)
      GRP_OVL: return 8'h07;
      GRP_REF: return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] grp_rst(input int g);
    return (g == GRP_STD) ? 8'h80 : 8'h00;
  endfunction

  function automatic int grp_sb_pos(input int g);
    case (g)
      GRP_COM: return 7;
      GRP_STD: return 5;
      GRP_OVL: return 0;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/stat_evt_group.sv
module stat_evt_group #(
  parameter int DW = 8,
  parameter logic [DW-1:0] VALID = '1,
  parameter logic [DW-1:0] RSTV  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt_in,
  input  logic          rd_clr,
  input  logic          en_we,
  input  logic [DW-1:0] en_wdata,
  output logic [DW-1:0] evt_q,
  output logic [DW-1:0] en_q,
  output logic          summ
);
  logic [DW-1:0] evt_keep;

  // a read clears the old content; a new pulse in the same cycle survives
  assign evt_keep = rd_clr ? '0 : evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= RSTV & VALID;
      en_q  <= '0;
    end else begin
      evt_q <= evt_keep | (evt_in & VALID);
      if (en_we) en_q <= en_wdata & VALID;
    end
  end

  assign summ = |(evt_q & en_q);
endmodule

// File: rtl/stat_byte_unit.sv
module stat_byte_unit import stat_pkg::*; #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_N-1:0]  summ,
  input  logic              idle,
  input  logic              sre_we,
  input  logic [DW-1:0]     sre_wdata,
  output logic [DW-1:0]     sb,
  output logic [DW-1:0]     sre_q,
  output logic              msum
);
  logic [DW-1:0] sb_base;

  always_ff @(posedge clk) begin
    if (rst)         sre_q <= '0;
    else if (sre_we) sre_q <= sre_wdata & SRE_MASK;
  end

  always_comb begin
    sb_base = '0;
    for (int g = 0; g < GRP_N; g++) sb_base[grp_sb_pos(g)] = summ[g];
    sb_base[SB_IDLE_BIT] = idle;
  end

  assign msum = |(sb_base & sre_q);

  always_comb begin
    sb = sb_base;
    sb[SB_MSS_BIT] = msum;
  end
endmodule

// File: rtl/status_summary_tree.sv
module status_summary_tree import stat_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] comm_evt,
  input  logic [DW-1:0] std_evt,
  input  logic [DW-1:0] ovl_evt,
  input  logic [DW-1:0] ref_evt,
  input  logic          idle_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] stat_byte,
  output logic          srq
);
  logic [GRP_N-1:0][DW-1:0] evt_in;
  logic [GRP_N-1:0][DW-1:0] evt_q;
  logic [GRP_N-1:0][DW-1:0] en_q;
  logic [GRP_N-1:0]         summ;
  logic [DW-1:0]            sre_q;
  logic [DW-1:0]            rd_mux;

  assign evt_in[GRP_COM] = comm_evt;
  assign evt_in[GRP_STD] = std_evt;
  assign evt_in[GRP_OVL] = ovl_evt;
  assign evt_in[GRP_REF] = ref_evt;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    localparam int EV_ADDR = 2 * g;
    localparam int EN_ADDR = 2 * g + 1;
    logic rd_hit, wr_hit;
    assign rd_hit = reg_rd && (reg_addr == AW'(EV_ADDR));
    assign wr_hit = reg_wr && (reg_addr == AW'(EN_ADDR));
    stat_evt_group #(
      .DW(DW), .VALID(grp_mask(g)), .RSTV(grp_rst(g))
    ) u_grp (
      .clk(clk), .rst(rst), .evt_in(evt_in[g]), .rd_clr(rd_hit),
      .en_we(wr_hit), .en_wdata(reg_wdata),
      .evt_q(evt_q[g]), .en_q(en_q[g]), .summ(summ[g])
    );
  end

  stat_byte_unit #(.DW(DW)) u_sb (
    .clk(clk), .rst(rst), .summ(summ), .idle(idle_in),
    .sre_we(reg_wr && (reg_addr == AW'(ADDR_SRE))), .sre_wdata(reg_wdata),
    .sb(stat_byte), .sre_q(sre_q), .msum(srq)
  );

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (reg_addr == AW'(2 * g))     rd_mux = evt_q[g];
      if (reg_addr == AW'(2 * g + 1)) rd_mux = en_q[g];
    end
    if (reg_addr == AW'(ADDR_SB))  rd_mux = stat_byte;
    if (reg_addr == AW'(ADDR_SRE)) rd_mux = sre_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/status_summary_tree_chk.sv
module status_summary_tree_chk import stat_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_rd,
  input logic [AW-1:0]            reg_addr,
  input logic [GRP_N-1:0][DW-1:0] evt_in,
  input logic [GRP_N-1:0][DW-1:0] evt_q,
  input logic [GRP_N-1:0][DW-1:0] en_q,
  input logic [DW-1:0]            sre_q,
  input logic [DW-1:0]            stat_byte,
  input logic                     srq
);
  for (genvar g = 0; g < GRP_N; g++) begin : g_chk
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(reg_rd && reg_addr == AW'(2 * g)) |=> ((evt_q[g] & $past(evt_q[g])) == $past(evt_q[g])));
    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_rd && reg_addr == AW'(2 * g)) |=> ((evt_q[g] & ~$past(evt_in[g])) == '0));
    // R6
    undef_bits_chk: assert property (@(posedge clk) disable iff (rst)
      ((evt_q[g] | en_q[g]) & ~grp_mask(g)) == '0);
  end
  // R8
  srq_mirror_chk: assert property (@(posedge clk) disable iff (rst) srq == stat_byte[SB_MSS_BIT]);
  // R5
  sre_gap_chk: assert property (@(posedge clk) disable iff (rst) sre_q[SB_MSS_BIT] == 1'b0);
  // R7
  sb_gap_chk: assert property (@(posedge clk) disable iff (rst) stat_byte[3:2] == 2'b00);
endmodule

bind status_summary_tree status_summary_tree_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .evt_in(evt_in),
  .evt_q(evt_q), .en_q(en_q), .sre_q(sre_q), .stat_byte(stat_byte), .srq(srq)
);

// File: tb/tb_status_summary_tree.sv
module tb_status_summary_tree;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] comm_evt = 0, std_evt = 0, ovl_evt = 0, ref_evt = 0;
  logic idle_in = 0, reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, stat_byte;
  logic srq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  status_summary_tree dut (.*);

  function automatic logic [7:0] mask_of(int g);
    return (g == 2) ? 8'h07 : (g == 3) ? 8'h0F : 8'hFF;
  endfunction
  function automatic int pos_of(int g);
    return (g == 0) ? 7 : (g == 1) ? 5 : (g == 2) ? 0 : 1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_evt(int g, logic [7:0] v);
    case (g)
      0: comm_evt = v;
      1: std_evt  = v;
      2: ovl_evt  = v;
      default: ref_evt = v;
    endcase
  endtask

  task automatic pulse(int g, logic [7:0] v);
    @(negedge clk); set_evt(g, v);
    @(negedge clk); set_evt(g, 8'h00);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); reg_addr = 4'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk); reg_addr = 4'(a); reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    for (int a = 0; a < 10; a++) begin
      rd(a, d);
      chk("R1", d, (a == 2) ? 8'h80 : 8'h00);
    end
    chk("R1 sb", stat_byte, 8'h00);
    // R10 unmapped
    for (int a = 10; a < 16; a++) begin
      rd(a, d); chk("R10", d, 8'h00);
    end
    // R5 enable sweep
    for (int g = 0; g < 5; g++) begin
      for (int v = 0; v < 256; v += 7) begin
        wr(2 * g + 1, 8'(v)); rd(2 * g + 1, d);
        chk("R5", d, 8'(v) & ((g == 4) ? 8'hBF : mask_of(g)));
      end
      wr(2 * g + 1, 8'h00);
    end
    // R2 R3 R6 per-bit sticky capture and clear
    for (int g = 0; g < 4; g++) begin
      for (int b = 0; b < 8; b++) begin
        pulse(g, 8'(1 << b));
        repeat (3) @(negedge clk);
        wr(2 * g, 8'hFF);  // R6 write to event register ignored
        rd(2 * g, d); chk("R2 R6", d, 8'(1 << b) & mask_of(g));
        rd(2 * g, d); chk("R3", d, 8'h00);
      end
    end
    wr(8, 8'hFF);
    rd(8, d); chk("R6 sb write", d, 8'h00);
    // R4 event coinciding with read
    for (int g = 0; g < 4; g++) begin
      pulse(g, 8'h01);
      @(negedge clk); reg_addr = 4'(2 * g); reg_rd = 1; set_evt(g, 8'h02);
      @(negedge clk); reg_rd = 0; set_evt(g, 8'h00); d = reg_rdata;
      chk("R4 old", d, 8'h01);
      rd(2 * g, d); chk("R4 new", d, 8'h02);
    end
    // R7 R8 summary cascade
    for (int g = 0; g < 4; g++) begin
      for (int b = 0; b < 8; b++) begin
        if (mask_of(g)[b]) begin
          wr(2 * g + 1, 8'(1 << b));
          wr(9, 8'(1 << pos_of(g)));
          pulse(g, 8'(1 << b));
          chk("R7 R8 set", stat_byte, 8'(1 << pos_of(g)) | 8'h40);
          chk("R8 srq", {7'd0, srq}, 8'h01);
          wr(9, 8'h00);
          chk("R8 no sre", stat_byte, 8'(1 << pos_of(g)));
          rd(8, d); chk("R9", d, 8'(1 << pos_of(g)));
          chk("R9 kept", stat_byte, 8'(1 << pos_of(g)));
          wr(9, 8'(1 << pos_of(g)));
          rd(2 * g, d);
          chk("R8 drop", stat_byte, 8'h00);
          chk("R8 srq drop", {7'd0, srq}, 8'h00);
          // unmasked bit does not summarize
          pulse(g, 8'(~(1 << b)) & mask_of(g));
          chk("R7 masked", stat_byte, 8'h00);
          rd(2 * g, d);
        end
      end
      wr(2 * g + 1, 8'h00);
    end
    // R7 idle bit and R8 via idle
    wr(9, 8'h10);
    @(negedge clk); idle_in = 1;
    @(negedge clk);
    chk("R7 idle", stat_byte, 8'h50);
    chk("R8 idle srq", {7'd0, srq}, 8'h01);
    idle_in = 0;
    @(negedge clk);
    chk("R8 idle drop", stat_byte, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule